// File: doc/BRIEF.md
# Programmable Event Probe Unit

The probe watches one monitored value on every clock cycle. That value may be a performance counter or any other piece of processor state, and it arrives on a plain input port. Software programs a trigger value, a bit mask and a relational operation. The masked monitored value is compared with the masked trigger in every cycle. When the comparison turns true, the probe can raise a level interrupt, push an event record into an eight-entry on-chip queue, or do both. Each event record holds the probe's identifier, a free-running cycle stamp and the raw monitored value.

Configuration uses a small write port with four word addresses. Software drains the queue through a read/pop port. On that port the head record and a valid bit appear in the cycle the read is requested, and the entry is removed at the end of that cycle. Only the change of the comparison from false to true produces an event, so a condition that stays true cannot flood the queue.

Top module: `evp_unit`

## Requirements
- R1: After a synchronous active-low reset, `irq` and `ovf_flag` are 0, the queue is empty (a read returns `rd_valid`=0) and the cycle stamp counter is 0.
- R2: The control register (address 2) holds the operation code in bits [2:0]. Bits [1:0] select equal (00), less-than (01) or greater-than (10). Code 11 never matches. Bit [2] inverts the result, which gives not-equal, greater-or-equal and less-or-equal, with 111 matching always. Comparisons are unsigned.
- R3: Only the bits that are set in the mask register (address 1) take part in the comparison. Mask bits that are 0 clear the matching bit on both the monitored value and the trigger (address 0).
- R4: An event fires in a cycle where the comparison is true and it was false in the previous cycle. The comparison counts as false in the cycle before the first one after reset. A comparison that stays true gives exactly one event.
- R5: When control bit [3] is set, an event sets `irq` from the next cycle. `irq` stays at 1 until a write to address 3 with bit [0] set. If that acknowledge and a new event fall in the same cycle, `irq` stays at 1.
- R6: When control bit [4] is set, each event pushes a record {probe ID, cycle stamp, raw monitored value}. Records are read back in the order they were pushed. When the bit is clear, events push nothing.
- R7: The queue holds 8 records. An event that finds the queue full, judged before any pop in the same cycle, is dropped and sets the sticky `ovf_flag`. A write to address 3 with bit [1] set clears the flag, but a drop in the same cycle keeps it at 1.
- R8: While `pop_re` is high and the queue is not empty, `rd_valid` is 1 with the head record on `rd_id`/`rd_stamp`/`rd_value`, and the entry is popped at the end of that cycle. A read of an empty queue returns `rd_valid`=0 and changes nothing.
- R9: The stamp in a record equals the number of clock cycles since reset was released, counted at the cycle in which the event fired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_val | input | DATA_W | Monitored value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Write address: 0 trigger, 1 mask, 2 control, 3 command |
| cfg_wdata | input | WR_W (max of DATA_W and 5) | Write data |
| pop_re | input | 1 | Read and pop the queue head |
| rd_valid | output | 1 | Head record is valid this cycle |
| rd_id | output | ID_W | Probe identifier of the record |
| rd_stamp | output | TS_W | Cycle stamp of the record |
| rd_value | output | DATA_W | Monitored value captured by the record |
| irq | output | 1 | Level interrupt request |
| ovf_flag | output | 1 | Sticky queue-overflow flag |

## Verification
Three collisions in the same cycle are provoked on purpose. An event that arrives with a full queue while software pops the head must still be dropped: the bench pops during the firing cycle and then expects seven records and a set overflow flag. An interrupt acknowledge written in the same cycle as a fresh event must leave the interrupt set. An overflow-clear write that coincides with a new drop must leave the flag set. The comparator is swept over every operation code, trigger and monitored value for a full mask and a partial mask, and each result is judged against an arithmetic model of the masked unsigned compare.

// File: rtl/evp_pkg.sv
// Package: shared encodings for the event probe unit.
// Assumes the configuration port has a two-bit word address.
package evp_pkg;

    // Relational selector held in control bits [1:0]
    typedef enum logic [1:0] {
        CMP_EQ   = 2'b00,
        CMP_LT   = 2'b01,
        CMP_GT   = 2'b10,
        CMP_NONE = 2'b11
    } cmp_sel_e;

    // Configuration word addresses
    localparam logic [1:0] ADR_TRIG = 2'd0;
    localparam logic [1:0] ADR_MASK = 2'd1;
    localparam logic [1:0] ADR_CTRL = 2'd2;
    localparam logic [1:0] ADR_CMD  = 2'd3;

    // Control field positions
    localparam int CTRL_INV_BIT  = 2;
    localparam int CTRL_IRQ_BIT  = 3;
    localparam int CTRL_QEN_BIT  = 4;

    // Command field positions
    localparam int CMD_ACK_BIT   = 0;
    localparam int CMD_OCLR_BIT  = 1;

endpackage

// File: rtl/evp_cfg_regs.sv
// Configuration registers of the probe: trigger, mask, control and
// one-cycle command strobes. Assumes WR_W >= 5 so that the control
// and command fields fit in the write word.
module evp_cfg_regs
    import evp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int WR_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [WR_W-1:0]   wdata,
    output logic [DATA_W-1:0] trig,
    output logic [DATA_W-1:0] mask,
    output cmp_sel_e          sel,
    output logic              inv,
    output logic              irq_en,
    output logic              q_en,
    output logic              ack,
    output logic              ovf_clr
);

    // Register updates on configuration writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig   <= '0;
            mask   <= '0;
            sel    <= CMP_EQ;
            inv    <= 1'b0;
            irq_en <= 1'b0;
            q_en   <= 1'b0;
        end else if (we) begin
            case (addr)
                ADR_TRIG: trig <= wdata[DATA_W-1:0];
                ADR_MASK: mask <= wdata[DATA_W-1:0];
                ADR_CTRL: begin
                    sel    <= cmp_sel_e'(wdata[1:0]);
                    inv    <= wdata[CTRL_INV_BIT];
                    irq_en <= wdata[CTRL_IRQ_BIT];
                    q_en   <= wdata[CTRL_QEN_BIT];
                end
                default: ;
            endcase
        end
    end

    // Command strobes act in the cycle of the write itself
    always_comb begin
        ack     = we && (addr == ADR_CMD) && wdata[CMD_ACK_BIT];
        ovf_clr = we && (addr == ADR_CMD) && wdata[CMD_OCLR_BIT];
    end

endmodule

// File: rtl/evp_compare.sv
// Masked unsigned comparator with rising-edge event detection.
// Assumes the monitored value is synchronous to clk. The previous
// match state resets to false.
module evp_compare
    import evp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] mon,
    input  logic [DATA_W-1:0] trig,
    input  logic [DATA_W-1:0] mask,
    input  cmp_sel_e          sel,
    input  logic              inv,
    output logic              fire
);

    logic [DATA_W-1:0] mon_m;
    logic [DATA_W-1:0] trig_m;
    logic              raw;
    logic              match;
    logic              match_q;

    // Masked operands and the selected relation
    always_comb begin
        mon_m  = mon & mask;
        trig_m = trig & mask;
        unique case (sel)
            CMP_EQ:  raw = (mon_m == trig_m);
            CMP_LT:  raw = (mon_m <  trig_m);
            CMP_GT:  raw = (mon_m >  trig_m);
            default: raw = 1'b0;
        endcase
        match = raw ^ inv;
    end

    // Remember last cycle's match for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match;
    end

    // Event on a false-to-true transition only
    always_comb fire = match && !match_q;

endmodule

// File: rtl/evp_event_fifo.sv
// Event record queue with a drop-on-full policy. Fullness is judged
// on the occupancy before any pop in the same cycle. The head record
// is visible combinationally.
module evp_event_fifo #(
    parameter int ID_W   = 4,
    parameter int TS_W   = 32,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [ID_W-1:0]   in_id,
    input  logic [TS_W-1:0]   in_stamp,
    input  logic [DATA_W-1:0] in_value,
    input  logic              pop_req,
    output logic              empty,
    output logic              drop,
    output logic [CNT_W-1:0]  count,
    output logic [ID_W-1:0]   hd_id,
    output logic [TS_W-1:0]   hd_stamp,
    output logic [DATA_W-1:0] hd_value
);

    logic [ID_W-1:0]   mem_id    [DEPTH];
    logic [TS_W-1:0]   mem_stamp [DEPTH];
    logic [DATA_W-1:0] mem_value [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              full;
    logic              do_push;
    logic              do_pop;

    // Pointer advance that wraps for any depth
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    // Status and qualified operations
    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        empty   = (count == '0);
        do_push = push_req && !full;
        do_pop  = pop_req && !empty;
        drop    = push_req && full;
    end

    // Storage write of an accepted record
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_id[wr_ptr]    <= in_id;
            mem_stamp[wr_ptr] <= in_stamp;
            mem_value[wr_ptr] <= in_value;
        end
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // Head record presented to the reader
    always_comb begin
        hd_id    = mem_id[rd_ptr];
        hd_stamp = mem_stamp[rd_ptr];
        hd_value = mem_value[rd_ptr];
    end

endmodule

// File: rtl/evp_unit.sv
// Event probe top level: config registers, comparator, record queue,
// cycle stamp counter, level interrupt and sticky overflow flag.
// Assumes a single clock domain and a monitored value sampled every cycle.
module evp_unit
    import evp_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ID_W        = 4,
    parameter int TS_W        = 32,
    parameter int DEPTH       = 8,
    parameter logic [ID_W-1:0] PROBE_ID = 4'h5,
    localparam int WR_W       = (DATA_W < 5) ? 5 : DATA_W,
    localparam int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] mon_val,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [WR_W-1:0]   cfg_wdata,
    input  logic              pop_re,
    output logic              rd_valid,
    output logic [ID_W-1:0]   rd_id,
    output logic [TS_W-1:0]   rd_stamp,
    output logic [DATA_W-1:0] rd_value,
    output logic              irq,
    output logic              ovf_flag
);

    logic [DATA_W-1:0] trig;
    logic [DATA_W-1:0] mask;
    cmp_sel_e          sel;
    logic              inv;
    logic              irq_en;
    logic              q_en;
    logic              ack;
    logic              ovf_clr;
    logic              fire;
    logic              q_empty;
    logic              q_drop;
    logic [CNT_W-1:0]  q_count;
    logic [TS_W-1:0]   stamp;

    evp_cfg_regs #(.DATA_W(DATA_W), .WR_W(WR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .trig(trig), .mask(mask), .sel(sel),
        .inv(inv), .irq_en(irq_en), .q_en(q_en), .ack(ack),
        .ovf_clr(ovf_clr)
    );

    evp_compare #(.DATA_W(DATA_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .mon(mon_val), .trig(trig),
        .mask(mask), .sel(sel), .inv(inv), .fire(fire)
    );

    evp_event_fifo #(
        .ID_W(ID_W), .TS_W(TS_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_req(fire && q_en),
        .in_id(PROBE_ID), .in_stamp(stamp), .in_value(mon_val),
        .pop_req(pop_re), .empty(q_empty), .drop(q_drop),
        .count(q_count), .hd_id(rd_id), .hd_stamp(rd_stamp),
        .hd_value(rd_value)
    );

    // Free-running cycle stamp
    always_ff @(posedge clk) begin
        if (!rst_n) stamp <= '0;
        else        stamp <= stamp + 1'b1;
    end

    // Level interrupt: a new event wins over a same-cycle acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)              irq <= 1'b0;
        else if (fire && irq_en) irq <= 1'b1;
        else if (ack)            irq <= 1'b0;
    end

    // Sticky overflow: a new drop wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_flag <= 1'b0;
        else if (q_drop)  ovf_flag <= 1'b1;
        else if (ovf_clr) ovf_flag <= 1'b0;
    end

    // Read valid in the cycle of a non-empty read
    always_comb rd_valid = pop_re && !q_empty;

endmodule

// File: rtl/evp_unit_chk.sv
// Assertion checker for evp_unit, attached by bind. Observes event,
// interrupt, overflow and queue occupancy behaviour over time.
module evp_unit_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fire,
    input logic             irq_en,
    input logic             q_en,
    input logic             ack,
    input logic             ovf_clr,
    input logic             irq,
    input logic             ovf_flag,
    input logic             pop_re,
    input logic             rd_valid,
    input logic [CNT_W-1:0] count
);

    // R4
    single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    // R5
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && irq_en) |=> irq);

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);

    // R5
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !(fire && irq_en)) |=> !irq);

    // R7
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R7
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R8
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (pop_re && count != '0));

    // R8
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_re && count == '0 && !(fire && q_en)) |=> (count == '0));

endmodule

bind evp_unit evp_unit_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fire(fire), .irq_en(irq_en), .q_en(q_en),
    .ack(ack), .ovf_clr(ovf_clr), .irq(irq), .ovf_flag(ovf_flag),
    .pop_re(pop_re), .rd_valid(rd_valid), .count(q_count)
);

// File: tb/evp_unit_tb_top.sv
// Self-checking bench: exhaustive comparator sweep on a 4-bit probe,
// then queue, interrupt and overflow scenarios with same-cycle collisions.
module evp_unit_tb_top;

    localparam int DW = 4;
    localparam int IW = 4;
    localparam int TW = 32;
    localparam int WW = 5;
    localparam logic [IW-1:0] PID = 4'hA;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] mon_val = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [WW-1:0] cfg_wdata = '0;
    logic          pop_re = 1'b0;
    logic          rd_valid;
    logic [IW-1:0] rd_id;
    logic [TW-1:0] rd_stamp;
    logic [DW-1:0] rd_value;
    logic          irq;
    logic          ovf_flag;

    int errors = 0;
    int checks = 0;
    int unsigned cyc = 0;
    bit done = 1'b0;

    logic [DW-1:0] mq_val[$];
    int unsigned   mq_ts[$];

    evp_unit #(.DATA_W(DW), .ID_W(IW), .TS_W(TW), .DEPTH(8), .PROBE_ID(PID)) dut_i (
        .clk(clk), .rst_n(rst_n), .mon_val(mon_val), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pop_re(pop_re),
        .rd_valid(rd_valid), .rd_id(rd_id), .rd_stamp(rd_stamp),
        .rd_value(rd_value), .irq(irq), .ovf_flag(ovf_flag)
    );

    always #5 clk = ~clk;

    // Bench cycle count since reset release (R9 model)
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit model(input logic [2:0] op, input logic [DW-1:0] t,
                                 input logic [DW-1:0] m, input logic [DW-1:0] v);
        logic [DW-1:0] a = v & m;
        logic [DW-1:0] b = t & m;
        bit r;
        case (op[1:0])
            2'b00: r = (a == b);
            2'b01: r = (a < b);
            2'b10: r = (a > b);
            default: r = 1'b0;
        endcase
        return r ^ op[2];
    endfunction

    task automatic wr(input logic [1:0] a, input logic [WW-1:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One event attempt: value v for a cycle then 0; optional same-cycle pop/command
    task automatic ev(input logic [DW-1:0] v, input bit qon, input bit pop,
                      input bit cmd, input logic [WW-1:0] cmdv);
        bit was_full = (mq_val.size() == 8);
        mon_val = v;
        if (pop) pop_re = 1'b1;
        if (cmd) begin cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = cmdv; end
        #2;
        if (pop) begin
            chk(rd_valid == 1'b1, "R8 pop during event valid", rd_valid, 1);
            chk(rd_value == mq_val[0], "R8 pop during event value", rd_value, mq_val[0]);
            void'(mq_val.pop_front());
            void'(mq_ts.pop_front());
        end
        if (qon && !was_full) begin
            mq_val.push_back(v);
            mq_ts.push_back(cyc);
        end
        @(negedge clk);
        pop_re = 1'b0; cfg_we = 1'b0;
        mon_val = '0;
        @(negedge clk);
    endtask

    task automatic pop_one(input string tag);
        pop_re = 1'b1;
        #2;
        if (mq_val.size() == 0) begin
            chk(rd_valid == 1'b0, {tag, " empty read"}, rd_valid, 0);
        end else begin
            chk(rd_valid == 1'b1, {tag, " valid"}, rd_valid, 1);
            chk(rd_value == mq_val[0], {tag, " value"}, rd_value, mq_val[0]);
            chk(rd_id == PID, "R6 record id", rd_id, PID);
            chk(rd_stamp == mq_ts[0], "R9 record stamp", rd_stamp, mq_ts[0]);
            void'(mq_val.pop_front());
            void'(mq_ts.pop_front());
        end
        @(negedge clk);
        pop_re = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);
        chk(ovf_flag == 1'b0, "R1 ovf after reset", ovf_flag, 0);
        pop_re = 1'b1; #2;
        chk(rd_valid == 1'b0, "R1 queue empty after reset", rd_valid, 0);
        @(negedge clk); pop_re = 1'b0;

        // R2 (full mask) and R3 (partial mask): exhaustive compare sweep via irq
        for (int mi = 0; mi < 2; mi++) begin
            logic [DW-1:0] m = (mi == 0) ? 4'hF : 4'h6;
            wr(2'd1, WW'(m));
            for (int t = 0; t < 16; t++) begin
                wr(2'd0, WW'(t));
                for (int op = 0; op < 8; op++) begin
                    for (int v = 0; v < 16; v++) begin
                        bit e;
                        wr(2'd2, 5'b01011);
                        wr(2'd3, 5'b00001);
                        mon_val = DW'(v);
                        wr(2'd2, WW'(8 + op));
                        @(negedge clk);
                        e = model(3'(op), DW'(t), m, DW'(v));
                        chk(irq == e, (mi == 0) ? "R2 compare op" : "R3 masked compare", irq, e);
                    end
                end
            end
        end
        wr(2'd2, 5'b00011);
        wr(2'd3, 5'b00011);
        chk(irq == 1'b0, "R5 ack clears irq", irq, 0);

        // R5/R6 enables clear: event raises nothing and queues nothing
        wr(2'd1, 5'h0F); wr(2'd0, 5'h00); mon_val = '0;
        wr(2'd2, 5'b00100);
        ev(4'd3, 1'b0, 1'b0, 1'b0, '0);
        chk(irq == 1'b0, "R5 irq gated by enable", irq, 0);
        pop_one("R6 queue gated by enable");

        // R4 steady match gives one record
        wr(2'd2, 5'b10100);
        @(negedge clk);
        mon_val = 4'd3;
        mq_val.push_back(4'd3); mq_ts.push_back(cyc);
        repeat (4) @(negedge clk);
        mon_val = '0; @(negedge clk);
        pop_one("R4 single record");
        pop_one("R4 no repeat record");

        // R6/R7/R9 fill past capacity, then drain in order
        for (int i = 1; i <= 10; i++) ev(DW'(i), 1'b1, 1'b0, 1'b0, '0);
        chk(ovf_flag == 1'b1, "R7 overflow set", ovf_flag, 1);
        for (int i = 0; i < 8; i++) pop_one("R6 fifo order");
        pop_one("R8 empty after drain");
        pop_one("R8 empty read again");
        chk(ovf_flag == 1'b1, "R7 overflow sticky", ovf_flag, 1);
        wr(2'd3, 5'b00010);
        chk(ovf_flag == 1'b0, "R7 overflow cleared", ovf_flag, 0);

        // R7 full judged before same-cycle pop
        for (int i = 1; i <= 8; i++) ev(DW'(i), 1'b1, 1'b0, 1'b0, '0);
        ev(4'd9, 1'b1, 1'b1, 1'b0, '0);
        chk(ovf_flag == 1'b1, "R7 drop with same-cycle pop", ovf_flag, 1);
        chk(mq_val.size() == 7, "R7 model depth", mq_val.size(), 7);
        for (int i = 0; i < 8; i++) pop_one("R7 remaining records");

        // R7 clear and new drop in the same cycle
        wr(2'd3, 5'b00010);
        for (int i = 1; i <= 8; i++) ev(DW'(i), 1'b1, 1'b0, 1'b0, '0);
        ev(4'd12, 1'b1, 1'b0, 1'b1, 5'b00010);
        chk(ovf_flag == 1'b1, "R7 drop wins over clear", ovf_flag, 1);
        for (int i = 0; i < 8; i++) pop_one("R7 drain");
        wr(2'd3, 5'b00010);

        // R5 acknowledge and new event in the same cycle
        wr(2'd2, 5'b01100);
        wr(2'd3, 5'b00001);
        chk(irq == 1'b0, "R5 irq idle", irq, 0);
        mon_val = 4'd7;
        wr(2'd3, 5'b00001);
        chk(irq == 1'b1, "R5 event wins over ack", irq, 1);
        @(negedge clk);
        chk(irq == 1'b1, "R5 irq level held", irq, 1);
        wr(2'd3, 5'b00001);
        chk(irq == 1'b0, "R5 ack with match held", irq, 0);
        pop_one("R6 no record with queue disabled");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule